// File: doc/BRIEF.md
# Two-Stage Address Translation Sequencer

This controller turns one memory access into a final host real address by running up to two table-walk stages through an external walker. Stage one maps a guest effective address to a guest real address using the process table. Stage two maps a guest real address to a host real address using the partition table. Which stages run depends on the access kind, the instruction and data relocation enables, the hypervisor flag and the partition number. The controller checks the process-table bounds and the partition configuration. It checks each stage's grant against the access. It merges page sizes and permissions across the stages, and it sorts every fault into a guest storage interrupt or one of two hypervisor storage interrupts, each with its own status-register update.

Requests use valid/ready. `req_ready` is high only while the controller is idle, and the request fields are taken in the cycle `req_valid && req_ready`. The walker request also uses valid/ready: once `walk_req_valid` rises, it and its payload hold steady until `walk_req_ready` is seen. The walker response has no ready, because the controller waits for it in a dedicated state and takes it in any cycle where `walk_rsp_valid` is high. The result is a one-cycle `done_valid` pulse with no back-pressure.

Top module: `xlt2_seq`

## Requirements
- R1: Relocation is on for a fetch (`req_kind`=2) when `ctl_ir` is set, and for a load (0) or store (1) when `ctl_dr` is set.
- R2: When relocation is off and `ctl_hv` is set, the result is class 0 (success) with address = effective address with bits [63:60] cleared, page size all ones, permissions 3'b111, and no walker request is issued.
- R3: When relocation is off and `ctl_hv` is clear, the effective address with bits [63:60] cleared becomes the guest real address, and only stage two runs.
- R4: A partition size field (`part_size`) below 5 ends any translating access with class 1 (guest storage) and cause bit 1, with no walker request.
- R5: With relocation on, if `ctl_pid`*16 is at least 2^(`ptab_size`+12), the access ends with class 1 and cause bit 0, with no walker request.
- R6: Stage two runs when `ctl_lpid` is nonzero or `ctl_hv` is clear. Otherwise the stage-one guest real address is the final address.
- R7: A successful result carries the minimum of the stage page sizes and the AND of the stage permission grants.
- R8: Permission bits are read (bit 0), write (bit 1) and execute (bit 2). A load needs read, a store needs write and a fetch needs execute. At stage one, a walker fault gives class 1 with the walker's cause, and a missing grant gives class 1 with cause bit 2.
- R9: A stage-two fault on a fetch gives class 2. `st_asdr` takes the guest real address and `st_err` takes the cause. A missing grant uses cause bit 2.
- R10: A stage-two fault on a load or store gives class 3. `st_hdsisr` takes the cause, plus bit 3 on a store. `st_hdar` takes the effective address, `st_asdr` takes the guest real address and `st_err` is cleared.
- R11: When both stages apply, stage two first translates the process-table entry location (base + `ctl_pid`*16) as a read. A fault there gives class 3 for every access kind, with cause bit 4 added, no store bit, and `st_asdr` = that entry location.
- R12: `done_valid` lasts exactly one cycle. The status registers change only on the edge that ends it. A class-1 fault loads `st_err` with the cause, and a success leaves all status registers unchanged.
- R13: `req_ready` is high only when no walk is in flight, and a pending walker request holds its payload until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Controller idle, request accepted |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_ea | input | EA_W | Effective address |
| ctl_ir | input | 1 | Instruction relocation enable |
| ctl_dr | input | 1 | Data relocation enable |
| ctl_hv | input | 1 | Hypervisor flag |
| ctl_lpid | input | LPID_W | Partition number |
| ctl_pid | input | PID_W | Process number |
| ptab_base | input | EA_W | Process table base |
| ptab_size | input | 5 | Process table size field |
| part_size | input | 5 | Partition root size field |
| walk_req_valid | output | 1 | Walker request valid |
| walk_req_ready | input | 1 | Walker accepts request |
| walk_req_stage2 | output | 1 | Request is a stage-two walk |
| walk_req_table | output | 1 | Stage-two walk of a table-entry location |
| walk_req_addr | output | EA_W | Address to translate |
| walk_req_root | output | EA_W | Process-table entry location (stage one) |
| walk_rsp_valid | input | 1 | Walker response valid |
| walk_rsp_fault | input | 1 | Walk found no valid entry |
| walk_rsp_cause | input | CAUSE_W | Walker fault cause |
| walk_rsp_addr | input | EA_W | Translated address |
| walk_rsp_psize | input | PSZ_W | Page size (log2) |
| walk_rsp_perm | input | 3 | Granted read/write/execute |
| done_valid | output | 1 | One-cycle completion pulse |
| res_class | output | 2 | 0 ok, 1 guest, 2 hyp fetch, 3 hyp data |
| res_addr | output | EA_W | Final real address |
| res_psize | output | PSZ_W | Combined page size |
| res_perm | output | 3 | Combined permissions |
| res_cause | output | CAUSE_W | Fault cause |
| st_asdr | output | EA_W | Guest real address of the fault |
| st_hdsisr | output | CAUSE_W | Hypervisor data fault cause |
| st_hdar | output | EA_W | Hypervisor data fault address |
| st_err | output | CAUSE_W | Error code |

## Verification
The assertions assume that the walker answers only after it has accepted a request, with exactly one response, and that `req_kind` never takes the value 3. The bench walker model answers one negedge after the accepting edge and returns only the fields set by the current stimulus vector. It can delay `walk_req_ready` to exercise the hold rule. Requests are driven only while `req_ready` is high, so control inputs never change while a walk is in flight.

// File: rtl/xlt2_pkg.sv
package xlt2_pkg;
  typedef enum logic [1:0] {XC_NONE = 2'd0, XC_GUEST = 2'd1, XC_HINST = 2'd2, XC_HDATA = 2'd3} xclass_e;
  typedef enum logic [1:0] {PH_TBL = 2'd0, PH_S1 = 2'd1, PH_S2 = 2'd2} phase_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WREQ = 2'd1, ST_WRSP = 2'd2, ST_FIN = 2'd3} state_e;

  localparam int CB_NOENT  = 0;
  localparam int CB_BADCFG = 1;
  localparam int CB_PROT   = 2;
  localparam int CB_STORE  = 3;
  localparam int CB_TABLE  = 4;

  function automatic logic [2:0] need_of(input logic [1:0] kind);
    case (kind)
      2'd1:    need_of = 3'b010;
      2'd2:    need_of = 3'b100;
      default: need_of = 3'b001;
    endcase
  endfunction
endpackage

// File: rtl/xlt2_mode_dec.sv
module xlt2_mode_dec #(
  parameter int EA_W      = 64,
  parameter int LPID_W    = 12,
  parameter int PID_W     = 20,
  parameter int SZF_W     = 5,
  parameter int ENT_SHIFT = 4,
  parameter int TOP_CLR   = 4
) (
  input  logic [1:0]        kind,
  input  logic              ir_en,
  input  logic              dr_en,
  input  logic              hv,
  input  logic [LPID_W-1:0] lpid,
  input  logic [PID_W-1:0]  pid,
  input  logic [EA_W-1:0]   ea,
  input  logic [EA_W-1:0]   tbl_base,
  input  logic [SZF_W-1:0]  tbl_size,
  input  logic [SZF_W-1:0]  part_size,
  output logic              reloc,
  output logic              real_only,
  output logic              need_s2,
  output logic              bad_cfg,
  output logic              out_of_range,
  output logic [EA_W-1:0]   ea_clr,
  output logic [EA_W-1:0]   entry_addr
);
  localparam int MIN_PART = 5;
  localparam int PAGE_SH  = 12;
  localparam logic [EA_W-1:0] CLR_MASK = {{TOP_CLR{1'b0}}, {(EA_W-TOP_CLR){1'b1}}};

  logic [EA_W-1:0] offset;
  int unsigned     lim_sh;

  always_comb begin
    reloc        = (kind == 2'd2) ? ir_en : dr_en;
    real_only    = !reloc && hv;
    need_s2      = (lpid != '0) || !hv;
    bad_cfg      = part_size < SZF_W'(MIN_PART);
    ea_clr       = ea & CLR_MASK;
    offset       = EA_W'(pid) << ENT_SHIFT;
    lim_sh       = int'(tbl_size) + PAGE_SH;
    out_of_range = |(offset >> lim_sh);
    entry_addr   = tbl_base + offset;
  end
endmodule

// File: rtl/xlt2_merge.sv
module xlt2_merge #(
  parameter int PSZ_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             upd,
  input  logic [PSZ_W-1:0] psize_in,
  input  logic [2:0]       perm_in,
  output logic [PSZ_W-1:0] psize,
  output logic [2:0]       perm
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psize <= '1;
      perm  <= 3'b111;
    end else if (init) begin
      psize <= '1;
      perm  <= 3'b111;
    end else if (upd) begin
      if (psize_in < psize) psize <= psize_in;
      perm <= perm & perm_in;
    end
  end

  p_psize_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !init) |=> (psize <= $past(psize)) && (psize <= $past(psize_in)));
endmodule

// File: rtl/xlt2_fault_route.sv
module xlt2_fault_route #(
  parameter int EA_W    = 64,
  parameter int CAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  xlt2_pkg::xclass_e  cls,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               is_store,
  input  logic [EA_W-1:0]    ea,
  input  logic [EA_W-1:0]    gra,
  output logic [EA_W-1:0]    asdr,
  output logic [CAUSE_W-1:0] hdsisr,
  output logic [EA_W-1:0]    hdar,
  output logic [CAUSE_W-1:0] err
);
  import xlt2_pkg::*;
  localparam logic [CAUSE_W-1:0] STORE_BIT = CAUSE_W'(1) << CB_STORE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asdr   <= '0;
      hdsisr <= '0;
      hdar   <= '0;
      err    <= '0;
    end else if (load) begin
      case (cls)
        XC_GUEST: err <= cause;
        XC_HINST: begin
          asdr <= gra;
          err  <= cause;
        end
        XC_HDATA: begin
          hdsisr <= cause | (is_store ? STORE_BIT : '0);
          hdar   <= ea;
          asdr   <= gra;
          err    <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xlt2_seq.sv
module xlt2_seq #(
  parameter int EA_W    = 64,
  parameter int LPID_W  = 12,
  parameter int PID_W   = 20,
  parameter int PSZ_W   = 6,
  parameter int CAUSE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic [EA_W-1:0]    req_ea,
  input  logic               ctl_ir,
  input  logic               ctl_dr,
  input  logic               ctl_hv,
  input  logic [LPID_W-1:0]  ctl_lpid,
  input  logic [PID_W-1:0]   ctl_pid,
  input  logic [EA_W-1:0]    ptab_base,
  input  logic [4:0]         ptab_size,
  input  logic [4:0]         part_size,
  output logic               walk_req_valid,
  input  logic               walk_req_ready,
  output logic               walk_req_stage2,
  output logic               walk_req_table,
  output logic [EA_W-1:0]    walk_req_addr,
  output logic [EA_W-1:0]    walk_req_root,
  input  logic               walk_rsp_valid,
  input  logic               walk_rsp_fault,
  input  logic [CAUSE_W-1:0] walk_rsp_cause,
  input  logic [EA_W-1:0]    walk_rsp_addr,
  input  logic [PSZ_W-1:0]   walk_rsp_psize,
  input  logic [2:0]         walk_rsp_perm,
  output logic               done_valid,
  output logic [1:0]         res_class,
  output logic [EA_W-1:0]    res_addr,
  output logic [PSZ_W-1:0]   res_psize,
  output logic [2:0]         res_perm,
  output logic [CAUSE_W-1:0] res_cause,
  output logic [EA_W-1:0]    st_asdr,
  output logic [CAUSE_W-1:0] st_hdsisr,
  output logic [EA_W-1:0]    st_hdar,
  output logic [CAUSE_W-1:0] st_err
);
  import xlt2_pkg::*;

  localparam logic [CAUSE_W-1:0] C_NOENT  = CAUSE_W'(1) << CB_NOENT;
  localparam logic [CAUSE_W-1:0] C_BADCFG = CAUSE_W'(1) << CB_BADCFG;
  localparam logic [CAUSE_W-1:0] C_PROT   = CAUSE_W'(1) << CB_PROT;
  localparam logic [CAUSE_W-1:0] C_TABLE  = CAUSE_W'(1) << CB_TABLE;

  state_e             st_q;
  phase_e             ph_q;
  xclass_e            cls_q;
  logic [1:0]         kind_q;
  logic               need_s2_q;
  logic               store_q;
  logic [EA_W-1:0]    ea_q, eaclr_q, entry_q, gra_q, final_q, fgra_q;
  logic [CAUSE_W-1:0] cause_q;

  logic            d_reloc, d_real, d_need_s2, d_bad, d_oor;
  logic [EA_W-1:0] d_eaclr, d_entry;

  xlt2_mode_dec #(.EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W)) u_dec (
    .kind(req_kind), .ir_en(ctl_ir), .dr_en(ctl_dr), .hv(ctl_hv),
    .lpid(ctl_lpid), .pid(ctl_pid), .ea(req_ea), .tbl_base(ptab_base),
    .tbl_size(ptab_size), .part_size(part_size),
    .reloc(d_reloc), .real_only(d_real), .need_s2(d_need_s2), .bad_cfg(d_bad),
    .out_of_range(d_oor), .ea_clr(d_eaclr), .entry_addr(d_entry)
  );

  logic       accept, rsp_take, grant_ok, stage_ok, merge_upd;
  logic [2:0] need_bits;

  always_comb begin
    accept    = (st_q == ST_IDLE) && req_valid;
    rsp_take  = (st_q == ST_WRSP) && walk_rsp_valid;
    need_bits = (ph_q == PH_TBL) ? 3'b001 : need_of(kind_q);
    grant_ok  = |(walk_rsp_perm & need_bits);
    stage_ok  = !walk_rsp_fault && grant_ok;
    merge_upd = rsp_take && stage_ok && (ph_q != PH_TBL);
  end

  xlt2_merge #(.PSZ_W(PSZ_W)) u_merge (
    .clk(clk), .rst_n(rst_n), .init(accept), .upd(merge_upd),
    .psize_in(walk_rsp_psize), .perm_in(walk_rsp_perm),
    .psize(res_psize), .perm(res_perm)
  );

  xlt2_fault_route #(.EA_W(EA_W), .CAUSE_W(CAUSE_W)) u_route (
    .clk(clk), .rst_n(rst_n), .load(st_q == ST_FIN), .cls(cls_q),
    .cause(cause_q), .is_store(store_q), .ea(ea_q), .gra(fgra_q),
    .asdr(st_asdr), .hdsisr(st_hdsisr), .hdar(st_hdar), .err(st_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  ph_q <= PH_S1;  cls_q <= XC_NONE;
      kind_q <= 2'd0;   need_s2_q <= 1'b0; store_q <= 1'b0;
      ea_q <= '0; eaclr_q <= '0; entry_q <= '0; gra_q <= '0;
      final_q <= '0; fgra_q <= '0; cause_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          ea_q      <= req_ea;
          eaclr_q   <= d_eaclr;
          kind_q    <= req_kind;
          need_s2_q <= d_need_s2;
          entry_q   <= d_entry;
          cls_q     <= XC_NONE;
          cause_q   <= '0;
          store_q   <= 1'b0;
          if (d_real) begin
            final_q <= d_eaclr;
            st_q    <= ST_FIN;
          end else if (d_bad) begin
            cls_q   <= XC_GUEST;
            cause_q <= C_BADCFG;
            st_q    <= ST_FIN;
          end else if (!d_reloc) begin
            gra_q <= d_eaclr;
            ph_q  <= PH_S2;
            st_q  <= ST_WREQ;
          end else if (d_oor) begin
            cls_q   <= XC_GUEST;
            cause_q <= C_NOENT;
            st_q    <= ST_FIN;
          end else begin
            ph_q <= d_need_s2 ? PH_TBL : PH_S1;
            st_q <= ST_WREQ;
          end
        end
        ST_WREQ: if (walk_req_ready) st_q <= ST_WRSP;
        ST_WRSP: if (walk_rsp_valid) begin
          case (ph_q)
            PH_TBL: begin
              if (!stage_ok) begin
                cls_q   <= XC_HDATA;
                cause_q <= (walk_rsp_fault ? walk_rsp_cause : C_PROT) | C_TABLE;
                fgra_q  <= entry_q;
                st_q    <= ST_FIN;
              end else begin
                entry_q <= walk_rsp_addr;
                ph_q    <= PH_S1;
                st_q    <= ST_WREQ;
              end
            end
            PH_S1: begin
              if (!stage_ok) begin
                cls_q   <= XC_GUEST;
                cause_q <= walk_rsp_fault ? walk_rsp_cause : C_PROT;
                st_q    <= ST_FIN;
              end else if (need_s2_q) begin
                gra_q <= walk_rsp_addr;
                ph_q  <= PH_S2;
                st_q  <= ST_WREQ;
              end else begin
                final_q <= walk_rsp_addr;
                st_q    <= ST_FIN;
              end
            end
            default: begin
              if (!stage_ok) begin
                cls_q   <= (kind_q == 2'd2) ? XC_HINST : XC_HDATA;
                cause_q <= walk_rsp_fault ? walk_rsp_cause : C_PROT;
                store_q <= (kind_q == 2'd1);
                fgra_q  <= gra_q;
              end else begin
                final_q <= walk_rsp_addr;
              end
              st_q <= ST_FIN;
            end
          endcase
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready       = (st_q == ST_IDLE);
    walk_req_valid  = (st_q == ST_WREQ);
    walk_req_stage2 = (ph_q != PH_S1);
    walk_req_table  = (ph_q == PH_TBL);
    walk_req_root   = entry_q;
    case (ph_q)
      PH_TBL:  walk_req_addr = entry_q;
      PH_S1:   walk_req_addr = eaclr_q;
      default: walk_req_addr = gra_q;
    endcase
    done_valid = (st_q == ST_FIN);
    res_class  = cls_q;
    res_addr   = final_q;
    res_cause  = cause_q;
  end

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
  p_status_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !done_valid |=> $stable(st_asdr) && $stable(st_hdsisr) && $stable(st_hdar) && $stable(st_err));
  p_walk_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_req_ready) |=> walk_req_valid && $stable(walk_req_addr) && $stable(walk_req_stage2));
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !walk_req_valid && !done_valid);
  p_ok_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && res_class == 2'd0) |-> (res_perm & need_of(kind_q)) != 3'b000);
endmodule

// File: tb/xlt2_seq_bench.sv
module xlt2_seq_bench;
  localparam int EA_W = 64;
  localparam logic [63:0] PT_BASE = 64'h0000_0000_0040_0000;

  typedef struct packed {
    logic [1:0] kind; logic ir; logic dr; logic hv;
    logic [11:0] lpid; logic [19:0] pid; logic [4:0] ptsz; logic [4:0] partsz;
    logic [63:0] ea;
    logic s1f; logic [2:0] s1perm; logic [5:0] s1psz;
    logic s2f; logic [2:0] s2perm; logic [5:0] s2psz;
    logic tblf; logic [2:0] tblperm;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b0,1'b1,1'b1,12'd0,20'd3,5'd0,5'd8,64'h0000_1234_5678_9000,1'b0,3'b001,6'd21,1'b0,3'b111,6'd30,1'b0,3'b111},
    '{2'd0,1'b0,1'b0,1'b1,12'd0,20'd3,5'd0,5'd8,64'hF000_0000_0000_4321,1'b0,3'b001,6'd21,1'b0,3'b111,6'd30,1'b0,3'b111},
    '{2'd2,1'b0,1'b1,1'b1,12'd0,20'd3,5'd0,5'd8,64'hA000_0000_0000_0ABC,1'b0,3'b111,6'd21,1'b0,3'b111,6'd30,1'b0,3'b111},
    '{2'd2,1'b1,1'b0,1'b0,12'd5,20'd7,5'd2,5'd9,64'h0000_0000_0012_3000,1'b0,3'b101,6'd21,1'b0,3'b110,6'd12,1'b0,3'b001},
    '{2'd0,1'b1,1'b0,1'b0,12'd0,20'd1,5'd0,5'd8,64'h3000_0000_0000_7000,1'b0,3'b111,6'd21,1'b0,3'b011,6'd30,1'b0,3'b111},
    '{2'd0,1'b0,1'b1,1'b0,12'd2,20'd1,5'd0,5'd4,64'h0000_0000_0000_1000,1'b0,3'b111,6'd21,1'b0,3'b111,6'd30,1'b0,3'b111},
    '{2'd0,1'b0,1'b1,1'b1,12'd0,20'd256,5'd0,5'd8,64'h0000_0000_0000_2000,1'b0,3'b111,6'd21,1'b0,3'b111,6'd30,1'b0,3'b111},
    '{2'd0,1'b0,1'b1,1'b1,12'd0,20'd255,5'd0,5'd8,64'h0000_0000_0000_2000,1'b0,3'b111,6'd16,1'b0,3'b111,6'd30,1'b0,3'b111},
    '{2'd1,1'b0,1'b1,1'b0,12'd9,20'd4,5'd0,5'd8,64'h0000_0000_0000_5000,1'b0,3'b011,6'd21,1'b1,3'b111,6'd30,1'b0,3'b111},
    '{2'd2,1'b1,1'b0,1'b1,12'd3,20'd4,5'd0,5'd8,64'h0000_0000_0000_6000,1'b0,3'b100,6'd21,1'b0,3'b011,6'd30,1'b0,3'b111},
    '{2'd2,1'b1,1'b0,1'b0,12'd1,20'd4,5'd0,5'd8,64'h0000_0000_0000_7000,1'b0,3'b100,6'd21,1'b0,3'b100,6'd30,1'b1,3'b111},
    '{2'd1,1'b0,1'b1,1'b1,12'd0,20'd4,5'd0,5'd8,64'h0000_0000_0000_8000,1'b0,3'b101,6'd21,1'b0,3'b111,6'd30,1'b0,3'b111},
    '{2'd0,1'b0,1'b1,1'b1,12'd0,20'd4,5'd0,5'd8,64'h0000_0000_0000_9000,1'b1,3'b111,6'd21,1'b0,3'b111,6'd30,1'b0,3'b111},
    '{2'd1,1'b0,1'b1,1'b0,12'd0,20'd4,5'd0,5'd8,64'h0000_0000_0000_A000,1'b0,3'b011,6'd21,1'b0,3'b010,6'd16,1'b0,3'b111},
    '{2'd0,1'b0,1'b1,1'b0,12'd1,20'd4,5'd0,5'd8,64'h0000_0000_0000_B000,1'b0,3'b111,6'd21,1'b0,3'b111,6'd30,1'b0,3'b110}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [63:0] req_ea = '0;
  logic ctl_ir = 1'b0, ctl_dr = 1'b0, ctl_hv = 1'b0;
  logic [11:0] ctl_lpid = '0;
  logic [19:0] ctl_pid = '0;
  logic [4:0] ptab_size = '0, part_size = 5'd8;
  logic walk_req_valid, walk_req_ready = 1'b1, walk_req_stage2, walk_req_table;
  logic [63:0] walk_req_addr, walk_req_root;
  logic walk_rsp_valid = 1'b0, walk_rsp_fault = 1'b0;
  logic [7:0] walk_rsp_cause = '0;
  logic [63:0] walk_rsp_addr = '0;
  logic [5:0] walk_rsp_psize = '0;
  logic [2:0] walk_rsp_perm = '0;
  logic done_valid;
  logic [1:0] res_class;
  logic [63:0] res_addr, st_asdr, st_hdar;
  logic [5:0] res_psize;
  logic [2:0] res_perm;
  logic [7:0] res_cause, st_hdsisr, st_err;

  xlt2_seq u_xlt2_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_ea(req_ea), .ctl_ir(ctl_ir), .ctl_dr(ctl_dr),
    .ctl_hv(ctl_hv), .ctl_lpid(ctl_lpid), .ctl_pid(ctl_pid),
    .ptab_base(PT_BASE), .ptab_size(ptab_size), .part_size(part_size),
    .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready),
    .walk_req_stage2(walk_req_stage2), .walk_req_table(walk_req_table),
    .walk_req_addr(walk_req_addr), .walk_req_root(walk_req_root),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_fault(walk_rsp_fault),
    .walk_rsp_cause(walk_rsp_cause), .walk_rsp_addr(walk_rsp_addr),
    .walk_rsp_psize(walk_rsp_psize), .walk_rsp_perm(walk_rsp_perm),
    .done_valid(done_valid), .res_class(res_class), .res_addr(res_addr),
    .res_psize(res_psize), .res_perm(res_perm), .res_cause(res_cause),
    .st_asdr(st_asdr), .st_hdsisr(st_hdsisr), .st_hdar(st_hdar), .st_err(st_err)
  );

  int n_chk = 0, n_bad = 0;
  vec_t cur;
  int walks = 0;
  int stall_left = 0;
  logic pend = 1'b0;
  logic p_s2, p_tbl;
  logic [63:0] p_addr;

  // walker model: answers one negedge after the accepting edge
  always @(negedge clk) begin
    if (pend) begin
      walk_rsp_valid = 1'b1;
      if (!p_s2) begin
        walk_rsp_fault = cur.s1f; walk_rsp_cause = 8'h40;
        walk_rsp_addr = p_addr ^ 64'h0000_0000_0AB0_0000;
        walk_rsp_psize = cur.s1psz; walk_rsp_perm = cur.s1perm;
      end else if (p_tbl) begin
        walk_rsp_fault = cur.tblf; walk_rsp_cause = 8'h20;
        walk_rsp_addr = p_addr + 64'h100;
        walk_rsp_psize = 6'd30; walk_rsp_perm = cur.tblperm;
      end else begin
        walk_rsp_fault = cur.s2f; walk_rsp_cause = 8'h80;
        walk_rsp_addr = p_addr + 64'h8000_0000;
        walk_rsp_psize = cur.s2psz; walk_rsp_perm = cur.s2perm;
      end
      pend = 1'b0;
    end else begin
      walk_rsp_valid = 1'b0;
    end
    walk_req_ready = (stall_left == 0);
    if (stall_left > 0) stall_left = stall_left - 1;
    if (walk_req_valid && walk_req_ready) begin
      pend = 1'b1; p_s2 = walk_req_stage2; p_tbl = walk_req_table;
      p_addr = walk_req_addr; walks = walks + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // shadow status registers
  logic [63:0] sh_asdr = '0, sh_hdar = '0;
  logic [7:0] sh_hdsisr = '0, sh_err = '0;
  logic [1:0] e_cls; logic [63:0] e_addr; logic [5:0] e_psz; logic [2:0] e_perm;
  logic [7:0] e_cause; int e_walks;

  task automatic model(input vec_t v);
    logic reloc, s2need, ok;
    logic [63:0] eac, entry, gra;
    logic [2:0] need;
    reloc = (v.kind == 2'd2) ? v.ir : v.dr;                     // R1
    eac = v.ea & 64'h0FFF_FFFF_FFFF_FFFF;
    need = (v.kind == 2'd1) ? 3'b010 : (v.kind == 2'd2) ? 3'b100 : 3'b001;
    e_cls = 2'd0; e_addr = 64'h0; e_psz = 6'h3F; e_perm = 3'b111; e_cause = 8'h0; e_walks = 0;
    s2need = (v.lpid != 12'd0) || !v.hv;
    gra = eac;
    if (!reloc && v.hv) begin e_addr = eac; return; end           // R2
    if (v.partsz < 5'd5) begin e_cls = 2'd1; e_cause = 8'h02; sh_err = 8'h02; return; end
    if (reloc) begin
      if (({44'h0, v.pid} << 4) >= (64'd1 << (v.ptsz + 5'd12))) begin
        e_cls = 2'd1; e_cause = 8'h01; sh_err = 8'h01; return;   // R5
      end
      entry = PT_BASE + ({44'h0, v.pid} << 4);
      if (s2need) begin
        e_walks++;
        if (v.tblf || !v.tblperm[0]) begin                        // R11
          e_cls = 2'd3; e_cause = (v.tblf ? 8'h20 : 8'h04) | 8'h10;
          sh_hdsisr = e_cause; sh_hdar = v.ea; sh_asdr = entry; sh_err = 8'h00; return;
        end
      end
      e_walks++;
      ok = |(v.s1perm & need);
      if (v.s1f || !ok) begin
        e_cls = 2'd1; e_cause = v.s1f ? 8'h40 : 8'h04; sh_err = e_cause; return;
      end
      gra = eac ^ 64'h0000_0000_0AB0_0000;
      e_psz = v.s1psz; e_perm = v.s1perm;
      if (!s2need) begin e_addr = gra; return; end
    end
    e_walks++;
    ok = |(v.s2perm & need);
    if (v.s2f || !ok) begin
      e_cause = v.s2f ? 8'h80 : 8'h04;
      if (v.kind == 2'd2) begin e_cls = 2'd2; sh_asdr = gra; sh_err = e_cause; end
      else begin
        e_cls = 2'd3; sh_hdsisr = e_cause | ((v.kind == 2'd1) ? 8'h08 : 8'h00);
        sh_hdar = v.ea; sh_asdr = gra; sh_err = 8'h00;
      end
      return;
    end
    e_addr = gra + 64'h8000_0000;
    if (v.s2psz < e_psz) e_psz = v.s2psz;
    e_perm = e_perm & v.s2perm;
  endtask

  task automatic run(input vec_t v, input string tag);
    int guard;
    bit seen;
    cur = v; walks = 0;
    @(negedge clk);
    req_kind = v.kind; req_ea = v.ea; ctl_ir = v.ir; ctl_dr = v.dr; ctl_hv = v.hv;
    ctl_lpid = v.lpid; ctl_pid = v.pid; ptab_size = v.ptsz; part_size = v.partsz;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    model(v);
    seen = done_valid;
    guard = 0;
    while (!seen && guard < 100) begin
      if (walk_req_valid && !walk_req_ready)
        chk("R13", "held request", {63'h0, req_ready}, 64'h0);
      @(negedge clk);
      seen = done_valid; guard++;
    end
    chk(tag, "done seen", {63'h0, seen}, 64'h1);
    chk(tag, "class", {62'h0, res_class}, {62'h0, e_cls});
    if (e_cls == 2'd0) begin
      chk(tag, "addr", res_addr, e_addr);
      chk("R7", "psize", {58'h0, res_psize}, {58'h0, e_psz});
      chk("R7", "perm", {61'h0, res_perm}, {61'h0, e_perm});
    end else begin
      chk(tag, "cause", {56'h0, res_cause}, {56'h0, e_cause});
    end
    chk(tag, "walker count", 64'(walks), 64'(e_walks));
    @(negedge clk);
    chk("R12", "pulse ends", {63'h0, done_valid}, 64'h0);
    chk("R12", "asdr", st_asdr, sh_asdr);
    chk("R12", "hdsisr", {56'h0, st_hdsisr}, {56'h0, sh_hdsisr});
    chk("R12", "hdar", st_hdar, sh_hdar);
    chk("R12", "err", {56'h0, st_err}, {56'h0, sh_err});
  endtask

  localparam string TAGS [NV] = '{"R6","R2","R1","R7","R3","R4","R5","R5","R10","R9","R11","R8","R8","R6","R11"};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", "reset ready", {63'h0, req_ready}, 64'h1);
    chk("R12", "reset done", {63'h0, done_valid}, 64'h0);
    chk("R12", "reset asdr", st_asdr, 64'h0);
    chk("R12", "reset err", {56'h0, st_err}, 64'h0);
    for (int i = 0; i < NV; i++) run(VECS[i], TAGS[i]);
    // stalled walker: request must hold until accepted
    stall_left = 4;
    run(VECS[3], "R13");
    stall_left = 6;
    run(VECS[8], "R13");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule